// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block owns the stack pointer and the program counter of a small 8-bit processor core. It carries out the control-flow and stack parts of an instruction once the decoder has classified it. These parts are single-byte pushes and pops, three call formats, a breakpoint trap, the two returns, and the fetch of the start address after reset. Instruction fetch, operand decode, interrupt arbitration and the ALU sit outside the block. The decoder presents a class code, a 16-bit argument, the return address and the current flag byte, together with a one-cycle start strobe. The block then runs the memory accesses that the class needs over a byte-wide request/acknowledge port.

Every stack access falls in the fixed page 0x01. The low address byte is the stack pointer, and it wraps within that page. A push writes first and decrements afterwards. A pop increments first and reads afterwards. With a memory that never stalls, each class occupies a fixed number of cycles. Wait states stretch an operation only when the accesses no longer fit inside that budget.

Top module: `stack_seq`

## Requirements
- R1: Every stack access uses the address {0x01, SP}. SP wraps modulo 256 in both directions: a pop at SP=0xFF reads 0x0100 and leaves SP=0x00, and a push at SP=0x00 writes 0x0100 and leaves SP=0xFF.
- R2: A push (class 0) writes the low byte of the argument at the current SP, then decrements SP by one.
- R3: A pop (class 1) increments SP, reads from the new address and shows the byte on `pop_data`. A flag pop (class 2) does the same, but the byte goes to `psw_out` with `psw_we` high in the done cycle, and `pop_data` keeps its value.
- R4: An absolute call (class 3) writes the return-address high byte at SP and the low byte at SP-1, leaves SP-2 and jumps to the argument. An upper-page call (class 4) pushes the same way and jumps to 0xFF00 plus the argument's low byte.
- R5: A table call (class 5) with index n (argument bits 3:0) pushes like R4. It then takes its target from 0xFFDE-2n (low byte) and 0xFFDF-2n (high byte).
- R6: A break (class 6) writes the return high byte at SP, the low byte at SP-1 and the flag input at SP-2, and leaves SP-3. It jumps through 0xFFDE/0xFFDF. In its done cycle it asserts `psw_we`, and `psw_out` is the flag input with bit 4 set and bit 2 cleared.
- R7: A return (class 7) pops the PC low byte and then the high byte, and jumps there. A return from interrupt (class 8) first pops a flag byte, which appears on `psw_out` with `psw_we`, and then pops the PC the same way.
- R8: After reset, SP is 0xFF. The block reads the low PC byte from 0xFFFE and the high byte from 0xFFFF, loads the PC, pulses `op_done`, and only then raises `op_ready`.
- R9: With a zero-wait memory, and counting the cycle in which the start is taken as 1, `op_done` is high in cycle 4 for classes 0-2, 8 for classes 3, 5 and 6, 6 for class 4, 5 for class 7 and 6 for class 8. `op_ready` is high the cycle after. The new PC is visible from that cycle.
- R10: A request holds its address, direction and write data until acknowledged. With w wait states per access and k accesses, `op_done` falls in cycle max(budget, k·(w+1)+2).
- R11: `op_start` while `op_ready` is low, including the done cycle, has no effect. No second operation runs and no extra stack write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start strobe, taken when op_ready is high |
| op_class | input | 4 | Operation class code |
| op_arg | input | 16 | Push byte, call target, page offset or table index |
| op_ret | input | 16 | Return address to be stacked by calls and break |
| psw_in | input | 8 | Current flag byte |
| op_ready | output | 1 | Idle, a start is accepted |
| op_done | output | 1 | Last cycle of an operation |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| pop_data | output | 8 | Byte from the latest data pop |
| psw_out | output | 8 | Flag byte to restore |
| psw_we | output | 1 | Load strobe for psw_out |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
A start strobe can fall in the same cycle as the done pulse of the running operation. The bench provokes this by holding `op_start` high from the start of a push through its done cycle, and by switching the class to an absolute call after the first cycle. The push counts as correct only if SP moved exactly once, the byte below it stayed untouched and the PC did not jump. The second overlap is between the fixed cycle budget and memory stalls. The bench runs break, return-from-interrupt and call with one and two wait states, and checks the done cycle against the larger of the two limits.

// File: rtl/ssq_pkg.sv
// Shared constants and types for the stack and subroutine sequencer.
// Assumes a 16-bit byte address space and a byte-wide data path.
package ssq_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;
    localparam int STEP_W = 3;
    localparam int IDX_W  = 4;

    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
    localparam logic [DATA_W-1:0] UPPER_PAGE = 8'hFF;
    localparam logic [ADDR_W-1:0] VEC_TABLE_TOP = 16'hFFDE;
    localparam logic [ADDR_W-1:0] VEC_RESET = 16'hFFFE;
    localparam logic [DATA_W-1:0] FLAG_BRK_SET = 8'h10;
    localparam logic [DATA_W-1:0] FLAG_IE_CLR  = 8'h04;

    typedef enum logic [3:0] {
        CL_PUSH  = 4'd0,
        CL_POP   = 4'd1,
        CL_POPF  = 4'd2,
        CL_CALL  = 4'd3,
        CL_PCALL = 4'd4,
        CL_TCALL = 4'd5,
        CL_BRK   = 4'd6,
        CL_RET   = 4'd7,
        CL_RETI  = 4'd8,
        CL_NOP   = 4'd9,
        CL_RSTV  = 4'd15
    } ssq_cls_e;

    typedef enum logic [1:0] {K_NONE, K_WR, K_POP, K_VEC} ssq_kind_e;
    typedef enum logic [1:0] {W_ARG, W_RHI, W_RLO, W_PSW} ssq_wsel_e;
    typedef enum logic [1:0] {D_RES, D_PSW, D_LO, D_HI} ssq_dsel_e;

    typedef struct packed {
        ssq_kind_e kind;
        ssq_wsel_e wsel;
        ssq_dsel_e dsel;
        logic      vec_hi;
    } ssq_step_t;
endpackage

// File: rtl/ssq_step_dec.sv
// Step decoder: for a class and a step index gives the access to perform,
// the number of accesses and the cycle budget of the class.
// Assumes the step index never exceeds the class's access count.
module ssq_step_dec
    import ssq_pkg::*;
(
    input  ssq_cls_e          cls,
    input  logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] n_steps,
    output logic [CNT_W-1:0]  budget,
    output ssq_step_t         st
);
    // Per-class sequence table
    always_comb begin
        n_steps = '0;
        budget  = 4'd2;
        st      = '{kind: K_NONE, wsel: W_ARG, dsel: D_RES, vec_hi: 1'b0};
        case (cls)
            CL_PUSH: begin
                n_steps = 3'd1; budget = 4'd4;
                st = '{kind: K_WR, wsel: W_ARG, dsel: D_RES, vec_hi: 1'b0};
            end
            CL_POP, CL_POPF: begin
                n_steps = 3'd1; budget = 4'd4;
                st = '{kind: K_POP, wsel: W_ARG,
                       dsel: (cls == CL_POPF) ? D_PSW : D_RES, vec_hi: 1'b0};
            end
            CL_CALL, CL_PCALL, CL_TCALL, CL_BRK: begin
                n_steps = (cls == CL_TCALL) ? 3'd4 : (cls == CL_BRK) ? 3'd5 : 3'd2;
                budget  = (cls == CL_PCALL) ? 4'd6 : 4'd8;
                case (step)
                    3'd0: st = '{kind: K_WR, wsel: W_RHI, dsel: D_RES, vec_hi: 1'b0};
                    3'd1: st = '{kind: K_WR, wsel: W_RLO, dsel: D_RES, vec_hi: 1'b0};
                    3'd2: st = (cls == CL_BRK)
                             ? '{kind: K_WR,  wsel: W_PSW, dsel: D_RES, vec_hi: 1'b0}
                             : '{kind: K_VEC, wsel: W_ARG, dsel: D_LO,  vec_hi: 1'b0};
                    3'd3: st = (cls == CL_BRK)
                             ? '{kind: K_VEC, wsel: W_ARG, dsel: D_LO,  vec_hi: 1'b0}
                             : '{kind: K_VEC, wsel: W_ARG, dsel: D_HI,  vec_hi: 1'b1};
                    default: st = '{kind: K_VEC, wsel: W_ARG, dsel: D_HI, vec_hi: 1'b1};
                endcase
            end
            CL_RET: begin
                n_steps = 3'd2; budget = 4'd5;
                st = '{kind: K_POP, wsel: W_ARG,
                       dsel: (step == 3'd0) ? D_LO : D_HI, vec_hi: 1'b0};
            end
            CL_RETI: begin
                n_steps = 3'd3; budget = 4'd6;
                st = '{kind: K_POP, wsel: W_ARG,
                       dsel: (step == 3'd0) ? D_PSW : (step == 3'd1) ? D_LO : D_HI,
                       vec_hi: 1'b0};
            end
            CL_RSTV: begin
                n_steps = 3'd2; budget = 4'd4;
                st = '{kind: K_VEC, wsel: W_ARG,
                       dsel: (step == 3'd0) ? D_LO : D_HI, vec_hi: step[0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ssq_sp.sv
// Stack pointer register. Wraps modulo 256; the stack page byte is fixed
// elsewhere. Assumes inc and dec are never high together.
module ssq_sp
    import ssq_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_SP = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] sp_up
);
    // Next value for a pre-increment pop
    assign sp_up = sp + 8'd1;

    // Pointer update on completed stack accesses
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= RESET_SP;
        else if (inc) sp <= sp_up;
        else if (dec) sp <= sp - 8'd1;
    end
endmodule

// File: rtl/ssq_addr.sv
// Address former: stack page accesses and vector-table reads.
// Assumes vector bases are even so the high byte sits at base | 1.
module ssq_addr
    import ssq_pkg::*;
(
    input  ssq_cls_e          cls,
    input  logic [IDX_W-1:0]  idx,
    input  ssq_kind_e         kind,
    input  logic              vec_hi,
    input  logic [DATA_W-1:0] sp,
    input  logic [DATA_W-1:0] sp_up,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] vec_base;

    // Vector base per class
    always_comb begin
        case (cls)
            CL_TCALL: vec_base = VEC_TABLE_TOP - {{(ADDR_W-IDX_W-1){1'b0}}, idx, 1'b0};
            CL_RSTV:  vec_base = VEC_RESET;
            default:  vec_base = VEC_TABLE_TOP;
        endcase
    end

    // Address select by access kind
    always_comb begin
        case (kind)
            K_WR:    addr = {STACK_PAGE, sp};
            K_POP:   addr = {STACK_PAGE, sp_up};
            K_VEC:   addr = {vec_base[ADDR_W-1:1], vec_hi};
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/stack_seq.sv
// Stack and subroutine sequencer top. Accepts one classified operation at a
// time, runs its memory accesses in order, pads to the class cycle budget and
// commits the new PC in the done cycle. Assumes mem_rdata is valid with mem_ack.
module stack_seq
    import ssq_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_SP = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [3:0]        op_class,
    input  logic [ADDR_W-1:0] op_arg,
    input  logic [ADDR_W-1:0] op_ret,
    input  logic [DATA_W-1:0] psw_in,
    output logic              op_ready,
    output logic              op_done,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] pop_data,
    output logic [DATA_W-1:0] psw_out,
    output logic              psw_we,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic              busy_q;
    ssq_cls_e          cls_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] arg_q, ret_q, tgt_q, pc_q, pc_next;
    logic [DATA_W-1:0] psw_save_q, pop_q, psw_q, sp_up;
    logic [STEP_W-1:0] n_steps;
    logic [CNT_W-1:0]  budget;
    ssq_step_t         st;
    logic [ADDR_W-1:0] acc_addr;
    logic              access, xfer, sp_inc, sp_dec;

    ssq_step_dec u_dec (
        .cls(cls_q), .step(step_q), .n_steps(n_steps), .budget(budget), .st(st)
    );

    ssq_sp #(.RESET_SP(RESET_SP)) u_sp (
        .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec), .sp(sp), .sp_up(sp_up)
    );

    ssq_addr u_addr (
        .cls(cls_q), .idx(arg_q[IDX_W-1:0]), .kind(st.kind), .vec_hi(st.vec_hi),
        .sp(sp), .sp_up(sp_up), .addr(acc_addr)
    );

    // Access and completion conditions
    always_comb begin
        access  = busy_q && (step_q < n_steps);
        xfer    = access && mem_ack;
        sp_dec  = xfer && (st.kind == K_WR);
        sp_inc  = xfer && (st.kind == K_POP);
        op_done = busy_q && (step_q == n_steps) && (cnt_q >= budget);
        psw_we  = op_done && (cls_q == CL_POPF || cls_q == CL_RETI || cls_q == CL_BRK);
    end

    // Memory request drive
    always_comb begin
        mem_req   = access;
        mem_we    = access && (st.kind == K_WR);
        mem_addr  = access ? acc_addr : '0;
        mem_wdata = '0;
        if (mem_we) begin
            case (st.wsel)
                W_ARG:   mem_wdata = arg_q[DATA_W-1:0];
                W_RHI:   mem_wdata = ret_q[ADDR_W-1:DATA_W];
                W_RLO:   mem_wdata = ret_q[DATA_W-1:0];
                default: mem_wdata = psw_save_q;
            endcase
        end
    end

    // PC target committed in the done cycle
    always_comb begin
        case (cls_q)
            CL_CALL:  pc_next = arg_q;
            CL_PCALL: pc_next = {UPPER_PAGE, arg_q[DATA_W-1:0]};
            CL_TCALL, CL_BRK, CL_RET, CL_RETI, CL_RSTV: pc_next = tgt_q;
            default:  pc_next = pc_q;
        endcase
    end

    // Sequencer state, operand latches and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b1;
            cls_q      <= CL_RSTV;
            step_q     <= '0;
            cnt_q      <= 4'd2;
            arg_q      <= '0;
            ret_q      <= '0;
            psw_save_q <= '0;
            tgt_q      <= '0;
            pc_q       <= '0;
            pop_q      <= '0;
            psw_q      <= '0;
        end else if (!busy_q) begin
            if (op_start) begin
                busy_q     <= 1'b1;
                cls_q      <= (op_class == CL_RSTV) ? CL_NOP : ssq_cls_e'(op_class);
                step_q     <= '0;
                cnt_q      <= 4'd2;
                arg_q      <= op_arg;
                ret_q      <= op_ret;
                psw_save_q <= psw_in;
                if (op_class == CL_BRK)
                    psw_q <= (psw_in | FLAG_BRK_SET) & ~FLAG_IE_CLR;
            end
        end else begin
            cnt_q <= (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
            if (xfer) begin
                step_q <= step_q + 1'b1;
                if (st.kind != K_WR) begin
                    case (st.dsel)
                        D_RES:   pop_q <= mem_rdata;
                        D_PSW:   psw_q <= mem_rdata;
                        D_LO:    tgt_q[DATA_W-1:0] <= mem_rdata;
                        default: tgt_q[ADDR_W-1:DATA_W] <= mem_rdata;
                    endcase
                end
            end
            if (op_done) begin
                busy_q <= 1'b0;
                pc_q   <= pc_next;
            end
        end
    end

    assign op_ready = !busy_q;
    assign pc       = pc_q;
    assign pop_data = pop_q;
    assign psw_out  = psw_q;
endmodule

// File: rtl/stack_seq_chk.sv
// Property checker for stack_seq, bound to every instance.
module stack_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_start,
    input logic        op_ready,
    input logic        op_done,
    input logic [7:0]  sp,
    input logic        psw_we,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_ack
);
    AST_WR_IN_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr[15:8] == 8'h01);  // R1
    AST_PUSH_POST_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> sp == $past(mem_addr[7:0]) - 8'd1);  // R2
    AST_POP_PRE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack && mem_addr[15:8] == 8'h01
        |=> sp == $past(mem_addr[7:0]));  // R3
    AST_FLAG_LOAD_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        psw_we |-> op_done);  // R3
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> op_ready);  // R9
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_ready && !op_done |=> !op_ready);  // R11
    AST_IDLE_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready && !op_start |=> op_ready);  // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
        && $stable(mem_wdata));  // R10
endmodule

bind stack_seq stack_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_ready(op_ready),
    .op_done(op_done), .sp(sp), .psw_we(psw_we), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;
    import ssq_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [3:0]  op_class = 4'd0;
    logic [15:0] op_arg = '0, op_ret = '0;
    logic [7:0]  psw_in = '0;
    logic        op_ready, op_done, psw_we, mem_req, mem_we, mem_ack;
    logic [15:0] pc, mem_addr;
    logic [7:0]  sp, pop_data, psw_out, mem_wdata, mem_rdata;

    stack_seq dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_class(op_class),
        .op_arg(op_arg), .op_ret(op_ret), .psw_in(psw_in), .op_ready(op_ready),
        .op_done(op_done), .pc(pc), .sp(sp), .pop_data(pop_data), .psw_out(psw_out),
        .psw_we(psw_we), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural memory: stack page and top page only
    logic [7:0] stk [256];
    logic [7:0] top [256];
    int waits = 0;
    int wcnt = 0;
    int cyc = 0;
    int n_chk = 0, n_bad = 0, done_cnt = 0;

    assign mem_ack = mem_req && (wcnt == waits);
    always_comb begin
        case (mem_addr[15:8])
            8'h01:   mem_rdata = stk[mem_addr[7:0]];
            8'hFF:   mem_rdata = top[mem_addr[7:0]];
            default: mem_rdata = 8'h00;
        endcase
    end
    always @(posedge clk) begin
        cyc <= cyc + 1;
        wcnt <= (mem_req && !mem_ack) ? wcnt + 1 : 0;
        if (mem_req && mem_we && mem_ack && mem_addr[15:8] == 8'h01)
            stk[mem_addr[7:0]] <= mem_wdata;
    end

    typedef struct {
        string tag;
        logic [15:0] epc;
        logic [7:0] esp, epop, epsw;
        bit cpsw;
        int ecyc, start;
    } rec_t;
    rec_t q[$];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the expected record on each done pulse and compares
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && op_done) begin
                rec_t r;
                if (q.size() == 0) begin
                    chk("R11", "unexpected done", 1, 0);
                end else begin
                    r = q.pop_front();
                    if (r.ecyc != 0) chk(r.tag, "cycles", cyc - r.start + 1, r.ecyc);
                    chk(r.tag, "psw_we", psw_we, r.cpsw);
                    if (r.cpsw) chk(r.tag, "psw_out", psw_out, r.epsw);
                    @(negedge clk);
                    chk(r.tag, "ready", op_ready, 1);
                    chk(r.tag, "pc", pc, r.epc);
                    chk(r.tag, "sp", sp, r.esp);
                    chk(r.tag, "pop_data", pop_data, r.epop);
                end
                done_cnt++;
            end
        end
    end

    // Driver: queues the expected result and runs one operation
    task automatic run_op(ssq_cls_e c, logic [15:0] arg, logic [15:0] ret, logic [7:0] psw,
                          logic [15:0] epc, logic [7:0] esp, logic [7:0] epop,
                          logic [7:0] epsw, bit cpsw, int ecyc, string tag, int hold);
        rec_t r;
        int n0;
        while (!op_ready) @(negedge clk);
        n0 = done_cnt;
        r.tag = tag; r.epc = epc; r.esp = esp; r.epop = epop; r.epsw = epsw;
        r.cpsw = cpsw; r.ecyc = ecyc; r.start = cyc;
        q.push_back(r);
        op_class = c; op_arg = arg; op_ret = ret; psw_in = psw; op_start = 1'b1;
        @(negedge clk);
        if (hold > 0) begin
            op_class = CL_CALL; op_arg = 16'hDEAD;
            repeat (hold) @(negedge clk);
        end
        op_start = 1'b0;
        while (done_cnt == n0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin stk[i] = 8'h00; top[i] = 8'h00; end
        for (int n = 0; n < 16; n++) begin
            top[8'hDE - 2*n] = 8'h10 + 8'(n);
            top[8'hDF - 2*n] = 8'h80 + 8'(n);
        end
        top[8'hFE] = 8'h34; top[8'hFF] = 8'h12;
        stk[8'h00] = 8'h5A;
        repeat (3) @(negedge clk);
        begin
            rec_t r;
            r.tag = "R8 reset vector"; r.epc = 16'h1234; r.esp = 8'hFF; r.epop = 8'h00;
            r.epsw = 8'h00; r.cpsw = 1'b0; r.ecyc = 0; r.start = 0;
            q.push_back(r);
        end
        rst_n = 1'b1;
        while (done_cnt == 0) @(negedge clk);
        chk("R8", "ready after fetch", op_ready, 1);

        // R1 R3: pop wraps FF -> 00
        run_op(CL_POP, 0, 0, 0, 16'h1234, 8'h00, 8'h5A, 0, 0, 4, "R1 R3 pop wrap", 0);
        // R1 R2: push wraps 00 -> FF
        run_op(CL_PUSH, 16'h00A7, 0, 0, 16'h1234, 8'hFF, 8'h5A, 0, 0, 4, "R1 R2 push wrap", 0);
        chk("R2", "stk[00]", stk[8'h00], 8'hA7);
        run_op(CL_PUSH, 16'h003C, 0, 0, 16'h1234, 8'hFE, 8'h5A, 0, 0, 4, "R2 push", 0);
        chk("R2", "stk[FF]", stk[8'hFF], 8'h3C);
        run_op(CL_POP, 0, 0, 0, 16'h1234, 8'hFF, 8'h3C, 0, 0, 4, "R3 pop", 0);
        run_op(CL_POP, 0, 0, 0, 16'h1234, 8'h00, 8'hA7, 0, 0, 4, "R3 pop", 0);

        // R4 absolute call and return (R7)
        run_op(CL_CALL, 16'h4567, 16'h2345, 0, 16'h4567, 8'hFE, 8'hA7, 0, 0, 8, "R4 call", 0);
        chk("R4", "ret hi at SP", stk[8'h00], 8'h23);
        chk("R4", "ret lo at SP-1", stk[8'hFF], 8'h45);
        run_op(CL_RET, 0, 0, 0, 16'h2345, 8'h00, 8'hA7, 0, 0, 5, "R7 ret", 0);
        // R4 upper-page call
        run_op(CL_PCALL, 16'h3399, 16'h1177, 0, 16'hFF99, 8'hFE, 8'hA7, 0, 0, 6, "R4 pcall", 0);
        chk("R4", "pcall hi", stk[8'h00], 8'h11);
        chk("R4", "pcall lo", stk[8'hFF], 8'h77);
        run_op(CL_RET, 0, 0, 0, 16'h1177, 8'h00, 8'hA7, 0, 0, 5, "R7 ret", 0);

        // R5 table calls at both ends and the middle
        run_op(CL_TCALL, 16'h0000, 16'h2222, 0, 16'h8010, 8'hFE, 8'hA7, 0, 0, 8, "R5 tcall 0", 0);
        run_op(CL_RET, 0, 0, 0, 16'h2222, 8'h00, 8'hA7, 0, 0, 5, "R7 ret", 0);
        run_op(CL_TCALL, 16'h000F, 16'h2223, 0, 16'h8F1F, 8'hFE, 8'hA7, 0, 0, 8, "R5 tcall 15", 0);
        run_op(CL_RET, 0, 0, 0, 16'h2223, 8'h00, 8'hA7, 0, 0, 5, "R7 ret", 0);
        run_op(CL_TCALL, 16'h0005, 16'h2224, 0, 16'h8515, 8'hFE, 8'hA7, 0, 0, 8, "R5 tcall 5", 0);
        run_op(CL_RET, 0, 0, 0, 16'h2224, 8'h00, 8'hA7, 0, 0, 5, "R7 ret", 0);

        // R6 break, R7 return from interrupt
        run_op(CL_BRK, 0, 16'h3456, 8'hC5, 16'h8010, 8'hFD, 8'hA7, 8'hD1, 1, 8, "R6 brk", 0);
        chk("R6", "brk hi", stk[8'h00], 8'h34);
        chk("R6", "brk lo", stk[8'hFF], 8'h56);
        chk("R6", "brk flags", stk[8'hFE], 8'hC5);
        run_op(CL_RETI, 0, 0, 0, 16'h3456, 8'h00, 8'hA7, 8'hC5, 1, 6, "R7 reti", 0);

        // R3 flag pop leaves pop_data alone
        run_op(CL_PUSH, 16'h002B, 0, 0, 16'h3456, 8'hFF, 8'hA7, 0, 0, 4, "R2 push", 0);
        run_op(CL_POPF, 0, 0, 0, 16'h3456, 8'h00, 8'hA7, 8'h2B, 1, 4, "R3 flag pop", 0);

        // R11 start held through busy and done cycles, class switched to call
        stk[8'hFF] = 8'h99;
        run_op(CL_PUSH, 16'h0011, 16'h7777, 0, 16'h3456, 8'hFF, 8'hA7, 0, 0, 4, "R11 held start", 3);
        chk("R11", "pushed byte", stk[8'h00], 8'h11);
        chk("R11", "no extra write", stk[8'hFF], 8'h99);
        chk("R11", "still ready", op_ready, 1);
        run_op(CL_POP, 0, 0, 0, 16'h3456, 8'h00, 8'h11, 0, 0, 4, "R3 pop", 0);

        // R10 wait states
        waits = 2;
        run_op(CL_BRK, 0, 16'h4242, 8'h04, 16'h8010, 8'hFD, 8'h11, 8'h10, 1, 17, "R10 brk waits", 0);
        chk("R10", "brk flags", stk[8'hFE], 8'h04);
        run_op(CL_RETI, 0, 0, 0, 16'h4242, 8'h00, 8'h11, 8'h04, 1, 11, "R10 reti waits", 0);
        waits = 1;
        run_op(CL_CALL, 16'hBEEF, 16'h0F0E, 0, 16'hBEEF, 8'hFE, 8'h11, 0, 0, 8, "R10 call budget", 0);
        chk("R10", "call hi", stk[8'h00], 8'h0F);
        chk("R10", "call lo", stk[8'hFF], 8'h0E);
        waits = 0;
        run_op(CL_RET, 0, 0, 0, 16'h0F0E, 8'h00, 8'h11, 0, 0, 5, "R9 ret", 0);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule